// File: doc/BRIEF.md
# Counting Semaphore Unit

A shared counting semaphore for N requester ports, for example the ports of several processor cores that compete for a pool of identical resources. Each port has two valid/ready channels. The acquire channel requests one unit from the pool. The release channel returns one unit. The unit keeps one non-negative count, which reset loads from a parameter. A single round-robin arbiter puts every operation on the count in sequence, one per cycle, so no two requesters ever touch the count in the same operation.

An acquire that finds the count above zero is granted in the cycle it wins arbitration. An acquire that finds the count at zero is parked in an in-order wait list, and the port keeps its valid raised. Later, a release hands its unit straight to the oldest parked port in the same cycle, and the count does not change. The count has a parameterized ceiling. A release at the ceiling is still accepted, but it raises a sticky error flag and the count stays where it is.

Back-pressure rules. Once a port raises acquire valid, it keeps it raised until it sees acquire ready. A port has at most one acquire outstanding. Release valid is held until release ready. The ready signals are combinational from the valids and the registered state. A parked port's acquire valid takes no further part in arbitration until that port is woken.

Top module: `csem_unit`

## Requirements
- R1: After reset the count equals INIT_COUNT, the error flag is 0, the wait list is empty and no ready is asserted.
- R2: An acquire that wins arbitration while the count is above zero sees acquire ready in that same cycle, and the count is one lower on the next cycle.
- R3: An acquire that wins arbitration while the count is zero gets no ready. The port is parked, and the count stays at zero.
- R4: A release that wins arbitration with no port parked sees release ready in that cycle, and the count is one higher on the next cycle.
- R5: A release that wins arbitration while ports are parked asserts acquire ready for one parked port in that same cycle, and the count stays unchanged.
- R6: Parked ports are woken in the order in which they were parked (oldest first).
- R7: At most one operation is accepted per cycle. The arbiter scans the ports starting at the one after the last accepted winner, and the pointer starts at port 0 after reset.
- R8: A release with the count at MAX_COUNT is accepted, but the count stays the same. The error flag goes to 1 and stays 1 until reset, whatever later operations occur.
- R9: The count stays within 0..MAX_COUNT at all times.
- R10: When a port raises release and acquire in the same cycle and wins arbitration, its release is served first, and its acquire competes again in a later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | NUM_PORTS | Acquire request per port, held until acq_ready |
| acq_ready | output | NUM_PORTS | Acquire grant per port (one unit handed over) |
| rel_valid | input | NUM_PORTS | Release request per port, held until rel_ready |
| rel_ready | output | NUM_PORTS | Release accepted per port |
| count | output | $clog2(MAX_COUNT+1) | Current number of free units |
| sat_err | output | 1 | Sticky flag: a release arrived with the count at its ceiling |

## Verification
Two functions can fall in one cycle: accepting a release and granting an acquire. When a port is parked, a release is accepted and a waiting acquire is handed the released unit in the same cycle. The bench provokes this by parking two ports and then releasing from other ports. It judges the result by the release and acquire readies seen together in that cycle, with the count held at zero on the next cycle. The same cycle can also be crowded by one port raising both channels, or by two ports releasing at once. In those cases the bench checks which single operation the arbiter accepts and that the other one follows in the next cycle.

// File: rtl/csem_pkg.sv
package csem_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_TAKE = 2'd1,
    OP_GIVE = 2'd2
  } sem_op_e;
endpackage

// File: rtl/csem_rr_arb.sv
module csem_rr_arb #(
  parameter int NUM_PORTS = 4,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  output logic                 win_valid,
  output logic [IW-1:0]        win_id
);
  logic [IW-1:0] start_q;
  int            scan;

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    scan      = 0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      scan = int'(start_q) + k;
      if (scan >= NUM_PORTS) scan = scan - NUM_PORTS;
      if (!win_valid && req[scan]) begin
        win_valid = 1'b1;
        win_id    = IW'(scan);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (win_valid) begin
      if (int'(win_id) == NUM_PORTS - 1) start_q <= '0;
      else                               start_q <= win_id + IW'(1);
    end
  end

  // R7
  win_is_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req[win_id]);
endmodule

// File: rtl/csem_wait_queue.sv
module csem_wait_queue #(
  parameter int NUM_PORTS = 4,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CW = $clog2(NUM_PORTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  input  logic          pop,
  output logic [IW-1:0] head_id,
  output logic          empty
);
  logic [IW-1:0] slot_q [NUM_PORTS];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  assign empty   = (fill_q == '0);
  assign head_id = slot_q[rd_q];

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    if (int'(p) == NUM_PORTS - 1) return '0;
    return p + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_id;
        wr_q         <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      if (push && !pop)      fill_q <= fill_q + CW'(1);
      else if (pop && !push) fill_q <= fill_q - CW'(1);
    end
  end

  // R3
  park_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(fill_q) < NUM_PORTS));
  // R5
  wake_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/csem_counter.sv
module csem_counter #(
  parameter int MAX_COUNT  = 7,
  parameter int INIT_COUNT = 1,
  localparam int CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] value,
  output logic          at_zero,
  output logic          at_max,
  output logic          err
);
  logic [CW-1:0] val_q;
  logic          err_q;

  assign value   = val_q;
  assign at_zero = (val_q == '0);
  assign at_max  = (val_q == CW'(MAX_COUNT));
  assign err     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= CW'(INIT_COUNT);
      err_q <= 1'b0;
    end else begin
      if (inc && at_max)        err_q <= 1'b1;
      else if (inc && !dec)     val_q <= val_q + CW'(1);
      if (dec && !inc && !at_zero) val_q <= val_q - CW'(1);
    end
  end

  // R9
  count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(val_q) <= MAX_COUNT);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !at_zero);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/csem_unit.sv
module csem_unit
  import csem_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int MAX_COUNT  = 7,
  parameter int INIT_COUNT = 1,
  localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CW = $clog2(MAX_COUNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] acq_valid,
  output logic [NUM_PORTS-1:0] acq_ready,
  input  logic [NUM_PORTS-1:0] rel_valid,
  output logic [NUM_PORTS-1:0] rel_ready,
  output logic [CW-1:0]        count,
  output logic                 sat_err
);
  logic [NUM_PORTS-1:0] parked_q;
  logic [NUM_PORTS-1:0] req;
  logic                 win_valid;
  logic [IW-1:0]        win_id;
  logic [IW-1:0]        head_id;
  logic                 q_empty;
  logic                 push, pop, inc, dec;
  logic                 at_zero, at_max;
  sem_op_e              op;

  assign req = rel_valid | (acq_valid & ~parked_q);

  csem_rr_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req),
    .win_valid(win_valid), .win_id(win_id)
  );

  csem_wait_queue #(.NUM_PORTS(NUM_PORTS)) u_waitq (
    .clk(clk), .rst_n(rst_n), .push(push), .push_id(win_id),
    .pop(pop), .head_id(head_id), .empty(q_empty)
  );

  csem_counter #(.MAX_COUNT(MAX_COUNT), .INIT_COUNT(INIT_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
    .value(count), .at_zero(at_zero), .at_max(at_max), .err(sat_err)
  );

  always_comb begin
    if (!win_valid)             op = OP_IDLE;
    else if (rel_valid[win_id]) op = OP_GIVE;
    else                        op = OP_TAKE;
  end

  always_comb begin
    acq_ready = '0;
    rel_ready = '0;
    push = 1'b0;
    pop  = 1'b0;
    inc  = 1'b0;
    dec  = 1'b0;
    case (op)
      OP_GIVE: begin
        rel_ready[win_id] = 1'b1;
        if (!q_empty) begin
          pop = 1'b1;
          acq_ready[head_id] = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      OP_TAKE: begin
        if (!at_zero) begin
          dec = 1'b1;
          acq_ready[win_id] = 1'b1;
        end else begin
          push = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked_q <= '0;
    end else begin
      if (push) parked_q[win_id]  <= 1'b1;
      if (pop)  parked_q[head_id] <= 1'b0;
    end
  end

  // R7
  one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_ready));
  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acq_ready));
  // R3
  grant_to_asker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ready & ~acq_valid) == '0);
  // R5
  handoff_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_ready && |acq_ready) |=> $stable(count));
  // R8
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_ready && at_max && q_empty) |=> (sat_err && $stable(count)));
endmodule

// File: tb/test_csem_unit.sv
module test_csem_unit;
  localparam int NP = 4;
  localparam int MX = 3;
  localparam int IN = 2;
  localparam int CW = $clog2(MX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] acq_valid = '0;
  logic [NP-1:0] rel_valid = '0;
  logic [NP-1:0] acq_ready, rel_ready;
  logic [CW-1:0] count;
  logic          sat_err;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  csem_unit #(.NUM_PORTS(NP), .MAX_COUNT(MX), .INIT_COUNT(IN)) i_csem_unit (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_ready(acq_ready),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .count(count), .sat_err(sat_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NP-1:0] pv, input logic [NP-1:0] vv);
    @(posedge clk); #1;
    acq_valid = pv;
    rel_valid = vv;
    @(negedge clk);
  endtask

  task automatic expect_grant(input int port);
    exp_q.push_back(port);
  endtask

  // monitor: every acquire grant must match the oldest expected one
  always @(negedge clk) begin
    if (rst_n && !done && |acq_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected grant actual=%0d expected=0", acq_ready);
      end else begin
        int want;
        want = exp_q.pop_front();
        if (acq_ready != NP'(1 << want)) begin
          errors++;
          $display("FAIL R6 grant order actual=%0d expected=%0d", acq_ready, 1 << want);
        end
      end
    end
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, IN);
    chk("R1 err", sat_err, 0);
    chk("R1 readies", {acq_ready, rel_ready}, 0);

    // R2 plain acquire
    expect_grant(0);
    cyc(4'b0001, 4'b0000);
    chk("R2 ready", acq_ready, 4'b0001);
    cyc(4'b0000, 4'b0000);
    chk("R2 count", count, 1);

    // R7 simultaneous acquires: pointer at 1, port 1 first
    expect_grant(1);
    cyc(4'b0110, 4'b0000);
    chk("R7 winner", acq_ready, 4'b0010);
    cyc(4'b0100, 4'b0000);
    chk("R3 no grant", acq_ready, 0);
    cyc(4'b0100, 4'b0000);
    chk("R3 count zero", count, 0);
    chk("R3 still parked", acq_ready, 0);

    // port 3 parks behind port 2
    cyc(4'b1100, 4'b0000);
    chk("R3 second park", acq_ready, 0);
    cyc(4'b1100, 4'b0000);
    chk("R3 count", count, 0);

    // R5 release hands off to oldest waiter
    expect_grant(2);
    cyc(4'b1100, 4'b0001);
    chk("R5 rel ready", rel_ready, 4'b0001);
    chk("R5 handoff", acq_ready, 4'b0100);
    cyc(4'b1000, 4'b0000);
    chk("R5 count held", count, 0);

    // R6 next waiter
    expect_grant(3);
    cyc(4'b1000, 4'b0010);
    chk("R6 second wake", acq_ready, 4'b1000);
    cyc(4'b0000, 4'b0000);
    chk("R6 count", count, 0);

    // R4 releases with nobody waiting
    cyc(4'b0000, 4'b0001);
    cyc(4'b0000, 4'b0010);
    cyc(4'b0000, 4'b0100);
    cyc(4'b0000, 4'b0000);
    chk("R4 count", count, 3);
    chk("R4 err", sat_err, 0);

    // R8 release at ceiling
    cyc(4'b0000, 4'b1000);
    chk("R8 accepted", rel_ready, 4'b1000);
    cyc(4'b0000, 4'b0000);
    chk("R8 count", count, 3);
    chk("R8 err", sat_err, 1);

    expect_grant(0);
    cyc(4'b0001, 4'b0000);
    chk("R2 grant", acq_ready, 4'b0001);
    cyc(4'b0000, 4'b0000);
    chk("R8 sticky", sat_err, 1);
    chk("R2 count", count, 2);

    // R10 same port raises both channels
    cyc(4'b0010, 4'b0010);
    chk("R10 release first", rel_ready, 4'b0010);
    chk("R10 acquire waits", acq_ready, 0);
    expect_grant(1);
    cyc(4'b0010, 4'b0000);
    chk("R10 acquire later", acq_ready, 4'b0010);
    cyc(4'b0000, 4'b0000);
    chk("R10 count", count, 2);

    // R7 pointer now at 2: port 3 beats port 0
    cyc(4'b0000, 4'b1001);
    chk("R7 rr winner", rel_ready, 4'b1000);
    cyc(4'b0000, 4'b0001);
    chk("R7 loser next", rel_ready, 4'b0001);
    cyc(4'b0000, 4'b0000);
    chk("R9 count bound", count, 3);
    chk("R8 err", sat_err, 1);

    chk("R6 all grants seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule